// File: doc/BRIEF.md
# Security Attribution and Alias Decoder

This block watches a 32-bit system address and reports, in the same cycle, the security view of that address. It gives the four-bit region number, whether the region is non-secure, whether it is non-secure-callable, and whether it lies in one of the two exempt windows. A two-bit configuration register enables the non-secure-callable marking separately for the two regions that can carry it. Software writes this register through a small write port, and its value can be read back at all times.

The same address is also folded and decoded. The secure mirror windows at regions 1, 3 and 5 are mapped back onto their physical targets in regions 0, 2 and 4. The folded address then selects one peripheral or the SRAM. A few control targets exist only in the region-5 window. They take priority over the plain mirror, and for them the address passes through unchanged. An address that matches nothing raises a no-target flag.

The block contains no sequencing. The configuration register is its only state, and every other output follows the address combinationally.

Top module: `secattr_decoder`

## Requirements
- R1: `region_id` equals address bits [31:28]. `is_nonsec` is 1 when address bit 28 is 0 and 0 when it is 1.
- R2: `is_nsc` is 1 for region 1 only while configuration bit 0 is 1, and for region 3 only while configuration bit 1 is 1. It is 0 for every other region.
- R3: `is_exempt` is 1 exactly when (address AND 0xEFF00000) equals 0xE0000000, which covers 0xE0000000–0xE00FFFFF and 0xF0000000–0xF00FFFFF.
- R4: Reset clears the configuration register, so `cfg_rd_data` reads 0 and no region is marked non-secure-callable.
- R5: A write with `cfg_wr_en` high stores only `cfg_wr_data[1:0]`. `cfg_rd_data[31:2]` always reads 0. The new value takes effect in the cycle after the clock edge that accepts the write. While `cfg_wr_en` is low, changes on `cfg_wr_data` have no effect.
- R6: For regions 1, 3 and 5, `phys_addr` is the address with bit 28 cleared. The exception is a region-5 secure-only target, which passes unchanged. All other addresses pass to `phys_addr` unchanged.
- R7: Each peripheral occupies one 4 KB page of the folded address. The page base and `target_sel` code for each one are:
  - 0x40000000, code 2
  - 0x40001000, code 3
  - 0x40002000, code 4
  - 0x40020000, code 5
  - 0x4002F000, code 6
  - 0x40080000, code 7
  - 0x40081000, code 8
- R8: Folded addresses 0x20000000–0x20007FFF (32 KB) select the SRAM with code 1. This includes accesses through the 0x3xxxxxxx mirror.
- R9: The following 4 KB pages select their target only in the 0x5xxxxxxx window, and they win over the mirror there:
  - 0x50083000, code 9
  - 0x50021000, code 10
  - 0x5002E000, code 11
  - 0x50081000, code 12
  - 0x50080000, code 7
- R10: When no target matches, `target_sel` is 0 and `no_target` is 1. Otherwise `no_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | 32 | Write data; only bits [1:0] are kept |
| cfg_rd_data | output | 32 | Current configuration, upper bits zero |
| addr_in | input | 32 | Address to attribute and decode |
| region_id | output | 4 | Region number (address top nibble) |
| is_nonsec | output | 1 | Region is non-secure |
| is_nsc | output | 1 | Region is non-secure-callable |
| is_exempt | output | 1 | Address is in an exempt window |
| phys_addr | output | 32 | Address after alias folding |
| target_sel | output | 4 | Selected target code (0 = none) |
| no_target | output | 1 | No target matched |

## Verification
The attribution, folding and decode outputs are due in the same cycle as the address that produces them. The bench therefore drives each address just after a falling edge and samples a nanosecond later, before the next rising edge. A configuration write becomes visible only after the rising edge that captures it. The bench samples once before that edge, to confirm the old value still holds, and once after the following falling edge, to see the new value both on `cfg_rd_data` and on `is_nsc`.

// File: rtl/secattr_pkg.sv
package secattr_pkg;

    typedef enum logic [3:0] {
        TGT_NONE     = 4'd0,
        TGT_SRAM     = 4'd1,
        TGT_TIMER0   = 4'd2,
        TGT_TIMER1   = 4'd3,
        TGT_DUALTMR  = 4'd4,
        TGT_SYSINFO  = 4'd5,
        TGT_SLOWTMR  = 4'd6,
        TGT_SECCTL   = 4'd7,
        TGT_NSWDOG   = 4'd8,
        TGT_MPCREG   = 4'd9,
        TGT_SYSCTL   = 4'd10,
        TGT_SLOWWDOG = 4'd11,
        TGT_SWDOG    = 4'd12
    } target_e;

endpackage

// File: rtl/secattr_cfg.sv
module secattr_cfg #(
    parameter int REG_W = 32,
    parameter int CFG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic [REG_W-1:0] rd_data
);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[REG_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[CFG_W-1:0] = cfg_q;
    end

endmodule

// File: rtl/secattr_attr.sv
module secattr_attr #(
    parameter int          ADDR_W       = 32,
    parameter int          REGION_W     = 4,
    parameter int          CFG_W        = 2,
    parameter logic [31:0] EXEMPT_MASK  = 32'hEFF0_0000,
    parameter logic [31:0] EXEMPT_MATCH = 32'hE000_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CFG_W-1:0]    cfg,
    output logic [REGION_W-1:0] region,
    output logic                nonsec,
    output logic                nsc,
    output logic                exempt
);

    logic [CFG_W-1:0] nsc_hit;

    assign region = addr[ADDR_W-1 -: REGION_W];
    assign nonsec = ~region[0];

    // configuration bit i enables callable marking of odd region 2*i+1
    for (genvar i = 0; i < CFG_W; i++) begin : g_nsc
        assign nsc_hit[i] = cfg[i] && (region == REGION_W'(2 * i + 1));
    end

    assign nsc    = |nsc_hit;
    assign exempt = ((addr & ADDR_W'(EXEMPT_MASK)) == ADDR_W'(EXEMPT_MATCH));

endmodule

// File: rtl/secattr_fold.sv
module secattr_fold #(
    parameter int ADDR_W    = 32,
    parameter int REGION_W  = 4,
    parameter int ALIAS_TOP = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] folded,
    output logic              in_alias
);

    localparam int SEC_BIT = ADDR_W - REGION_W;

    logic [REGION_W-1:0] region;

    assign region   = addr[ADDR_W-1 -: REGION_W];
    assign in_alias = region[0] && (region <= REGION_W'(ALIAS_TOP));

    always_comb begin
        folded = addr;
        if (in_alias) begin
            folded[SEC_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/secattr_target.sv
module secattr_target
    import secattr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SRAM_LOG2 = 15,
    parameter int PAGE_W    = ADDR_W - PAGE_BITS
) (
    input  logic [PAGE_W-1:0] raw_page,
    input  logic [PAGE_W-1:0] fold_page,
    output target_e           target,
    output logic              override_hit
);

    localparam int SRAM_HI_W = ADDR_W - SRAM_LOG2;

    // pages reachable through the folded address
    localparam logic [PAGE_W-1:0] PG_TIMER0  = PAGE_W'(32'h4000_0000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_TIMER1  = PAGE_W'(32'h4000_1000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_DUALTMR = PAGE_W'(32'h4000_2000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_SYSINFO = PAGE_W'(32'h4002_0000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_SLOWTMR = PAGE_W'(32'h4002_F000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_SECCTL  = PAGE_W'(32'h4008_0000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_NSWDOG  = PAGE_W'(32'h4008_1000 >> PAGE_BITS);

    // pages present only in the secure window, checked on the raw address
    localparam logic [PAGE_W-1:0] PG_S_SECCTL   = PAGE_W'(32'h5008_0000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_S_MPCREG   = PAGE_W'(32'h5008_3000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_S_SYSCTL   = PAGE_W'(32'h5002_1000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_S_SLOWWDOG = PAGE_W'(32'h5002_E000 >> PAGE_BITS);
    localparam logic [PAGE_W-1:0] PG_S_SWDOG    = PAGE_W'(32'h5008_1000 >> PAGE_BITS);

    localparam logic [SRAM_HI_W-1:0] SRAM_TAG = SRAM_HI_W'(32'h2000_0000 >> SRAM_LOG2);

    target_e ovr_tgt;
    target_e mir_tgt;

    always_comb begin
        unique case (raw_page)
            PG_S_SECCTL:   ovr_tgt = TGT_SECCTL;
            PG_S_MPCREG:   ovr_tgt = TGT_MPCREG;
            PG_S_SYSCTL:   ovr_tgt = TGT_SYSCTL;
            PG_S_SLOWWDOG: ovr_tgt = TGT_SLOWWDOG;
            PG_S_SWDOG:    ovr_tgt = TGT_SWDOG;
            default:       ovr_tgt = TGT_NONE;
        endcase
    end

    always_comb begin
        unique case (fold_page)
            PG_TIMER0:  mir_tgt = TGT_TIMER0;
            PG_TIMER1:  mir_tgt = TGT_TIMER1;
            PG_DUALTMR: mir_tgt = TGT_DUALTMR;
            PG_SYSINFO: mir_tgt = TGT_SYSINFO;
            PG_SLOWTMR: mir_tgt = TGT_SLOWTMR;
            PG_SECCTL:  mir_tgt = TGT_SECCTL;
            PG_NSWDOG:  mir_tgt = TGT_NSWDOG;
            default: begin
                if (fold_page[PAGE_W-1 -: SRAM_HI_W] == SRAM_TAG) begin
                    mir_tgt = TGT_SRAM;
                end else begin
                    mir_tgt = TGT_NONE;
                end
            end
        endcase
    end

    assign override_hit = (ovr_tgt != TGT_NONE);
    assign target       = override_hit ? ovr_tgt : mir_tgt;

endmodule

// File: rtl/secattr_decoder.sv
module secattr_decoder
    import secattr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int REGION_W  = 4,
    parameter int CFG_W     = 2,
    parameter int PAGE_BITS = 12,
    parameter int SRAM_LOG2 = 15,
    parameter int ALIAS_TOP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [REGION_W-1:0] region_id,
    output logic              is_nonsec,
    output logic              is_nsc,
    output logic              is_exempt,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [3:0]        target_sel,
    output logic              no_target
);

    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [CFG_W-1:0]  cfg_q;
    logic [ADDR_W-1:0] folded;
    logic              in_alias;
    logic              override_hit;
    target_e           tgt;

    secattr_cfg #(.REG_W(32), .CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg_q),
        .rd_data (cfg_rd_data)
    );

    secattr_attr #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .CFG_W(CFG_W)) u_attr (
        .addr   (addr_in),
        .cfg    (cfg_q),
        .region (region_id),
        .nonsec (is_nonsec),
        .nsc    (is_nsc),
        .exempt (is_exempt)
    );

    secattr_fold #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .ALIAS_TOP(ALIAS_TOP)) u_fold (
        .addr     (addr_in),
        .folded   (folded),
        .in_alias (in_alias)
    );

    secattr_target #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SRAM_LOG2(SRAM_LOG2), .PAGE_W(PAGE_W)
    ) u_tgt (
        .raw_page     (addr_in[ADDR_W-1:PAGE_BITS]),
        .fold_page    (folded[ADDR_W-1:PAGE_BITS]),
        .target       (tgt),
        .override_hit (override_hit)
    );

    // secure-only targets keep their own address; mirrors use the fold
    assign phys_addr  = (override_hit || !in_alias) ? addr_in : folded;
    assign target_sel = tgt;
    assign no_target  = (tgt == TGT_NONE);

endmodule

// File: rtl/secattr_checker.sv
module secattr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_wr_data,
    input logic [31:0] cfg_rd_data,
    input logic [31:0] addr_in,
    input logic [3:0]  region_id,
    input logic        is_nonsec,
    input logic        is_nsc,
    input logic        is_exempt,
    input logic [31:0] phys_addr,
    input logic [3:0]  target_sel,
    input logic        no_target
);

    p_nonsec_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_nonsec |-> !region_id[0]);

    p_nsc_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_nsc |-> (region_id == 4'd1 || region_id == 4'd3));

    p_nsc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nsc && region_id == 4'd1) |-> cfg_rd_data[0]);

    p_exempt_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_exempt |-> (addr_in[31:29] == 3'b111));

    p_reset_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rd_data == 32'd0));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[31:2] == 30'd0);

    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (cfg_rd_data[1:0] == $past(cfg_wr_data[1:0])));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rd_data));

    p_fold_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[31:29] == addr_in[31:29]) && (phys_addr[27:0] == addr_in[27:0]));

    p_override_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (target_sel >= 4'd9) |-> (addr_in[31:28] == 4'h5 && phys_addr == addr_in));

    p_none_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        no_target |-> (target_sel == 4'd0));

endmodule

bind secattr_decoder secattr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .addr_in     (addr_in),
    .region_id   (region_id),
    .is_nonsec   (is_nonsec),
    .is_nsc      (is_nsc),
    .is_exempt   (is_exempt),
    .phys_addr   (phys_addr),
    .target_sel  (target_sel),
    .no_target   (no_target)
);

// File: tb/secattr_decoder_test.sv
module secattr_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = 32'd0;
    logic [31:0] cfg_rd_data;
    logic [31:0] addr_in = 32'd0;
    logic [3:0]  region_id;
    logic        is_nonsec;
    logic        is_nsc;
    logic        is_exempt;
    logic [31:0] phys_addr;
    logic [3:0]  target_sel;
    logic        no_target;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    secattr_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .addr_in(addr_in), .region_id(region_id),
        .is_nonsec(is_nonsec), .is_nsc(is_nsc), .is_exempt(is_exempt),
        .phys_addr(phys_addr), .target_sel(target_sel), .no_target(no_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic exp_nsc, input logic exp_ex,
                         input logic [31:0] exp_phys, input logic [3:0] exp_tgt,
                         input string tgt_req);
        @(negedge clk);
        addr_in = a;
        #1;
        check("R1 region", {28'd0, region_id}, {28'd0, a[31:28]});
        check("R1 nonsec", {31'd0, is_nonsec}, {31'd0, ~a[28]});
        check("R2 nsc", {31'd0, is_nsc}, {31'd0, exp_nsc});
        check("R3 exempt", {31'd0, is_exempt}, {31'd0, exp_ex});
        check("R6 phys", phys_addr, exp_phys);
        check(tgt_req, {28'd0, target_sel}, {28'd0, exp_tgt});
        check("R10 no_target", {31'd0, no_target}, {31'd0, exp_tgt == 4'd0});
    endtask

    task automatic write_cfg(input logic [31:0] d, input logic exp_old);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = d;
        addr_in = 32'h1000_0000;
        #1;
        // R5: not yet visible before the capturing edge
        check("R5 pre-edge nsc", {31'd0, is_nsc}, {31'd0, exp_old});
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
        check("R5 readback", cfg_rd_data, {30'd0, d[1:0]});
    endtask

    task automatic t_reset_state;
        check("R4 reset rd", cfg_rd_data, 32'd0);
        probe(32'h1000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd0, "R10 reset r1");
        probe(32'h3000_0000, 1'b0, 1'b0, 32'h2000_0000, 4'd1, "R8 reset r3");
    endtask

    task automatic t_plain_regions;
        probe(32'h0000_1234, 1'b0, 1'b0, 32'h0000_1234, 4'd0, "R10 region0");
        probe(32'h1000_0010, 1'b0, 1'b0, 32'h0000_0010, 4'd0, "R6 mirror1");
        probe(32'h7000_0000, 1'b0, 1'b0, 32'h7000_0000, 4'd0, "R6 region7");
    endtask

    task automatic t_sram;
        probe(32'h2000_7FFC, 1'b0, 1'b0, 32'h2000_7FFC, 4'd1, "R8 sram top");
        probe(32'h3000_0004, 1'b0, 1'b0, 32'h2000_0004, 4'd1, "R8 sram mirror");
        probe(32'h2000_8000, 1'b0, 1'b0, 32'h2000_8000, 4'd0, "R8 sram edge");
    endtask

    task automatic t_nonsec_periph;
        probe(32'h4000_0010, 1'b0, 1'b0, 32'h4000_0010, 4'd2, "R7 timer0");
        probe(32'h4000_1FFC, 1'b0, 1'b0, 32'h4000_1FFC, 4'd3, "R7 timer1");
        probe(32'h4000_2000, 1'b0, 1'b0, 32'h4000_2000, 4'd4, "R7 dual");
        probe(32'h4002_0004, 1'b0, 1'b0, 32'h4002_0004, 4'd5, "R7 sysinfo");
        probe(32'h4002_F000, 1'b0, 1'b0, 32'h4002_F000, 4'd6, "R7 slowtmr");
        probe(32'h4008_0000, 1'b0, 1'b0, 32'h4008_0000, 4'd7, "R7 secctl");
        probe(32'h4008_1000, 1'b0, 1'b0, 32'h4008_1000, 4'd8, "R7 nswdog");
        probe(32'h4008_3000, 1'b0, 1'b0, 32'h4008_3000, 4'd0, "R9 mpc ns absent");
        probe(32'h4002_1000, 1'b0, 1'b0, 32'h4002_1000, 4'd0, "R9 sysctl ns absent");
    endtask

    task automatic t_secure_window;
        probe(32'h5000_0000, 1'b0, 1'b0, 32'h4000_0000, 4'd2, "R6 timer0 mirror");
        probe(32'h5002_F010, 1'b0, 1'b0, 32'h4002_F010, 4'd6, "R6 slowtmr mirror");
        probe(32'h5002_0000, 1'b0, 1'b0, 32'h4002_0000, 4'd5, "R6 sysinfo mirror");
        probe(32'h5008_0000, 1'b0, 1'b0, 32'h5008_0000, 4'd7, "R9 secctl");
        probe(32'h5008_3000, 1'b0, 1'b0, 32'h5008_3000, 4'd9, "R9 mpcreg");
        probe(32'h5002_1000, 1'b0, 1'b0, 32'h5002_1000, 4'd10, "R9 sysctl");
        probe(32'h5002_E000, 1'b0, 1'b0, 32'h5002_E000, 4'd11, "R9 slowwdog");
        probe(32'h5008_1000, 1'b0, 1'b0, 32'h5008_1000, 4'd12, "R9 swdog priority");
    endtask

    task automatic t_exempt;
        probe(32'hE000_0000, 1'b0, 1'b1, 32'hE000_0000, 4'd0, "R3 e low");
        probe(32'hE00F_FFFF, 1'b0, 1'b1, 32'hE00F_FFFF, 4'd0, "R3 e high");
        probe(32'hF008_0000, 1'b0, 1'b1, 32'hF008_0000, 4'd0, "R3 f mid");
        probe(32'hE010_0000, 1'b0, 1'b0, 32'hE010_0000, 4'd0, "R3 e past");
        probe(32'hF010_0000, 1'b0, 1'b0, 32'hF010_0000, 4'd0, "R3 f past");
    endtask

    task automatic t_nsc_config;
        write_cfg(32'hFFFF_FFFD, 1'b0);
        probe(32'h1000_0000, 1'b1, 1'b0, 32'h0000_0000, 4'd0, "R2 r1 on");
        probe(32'h3000_0000, 1'b0, 1'b0, 32'h2000_0000, 4'd1, "R2 r3 off");
        probe(32'h5000_0000, 1'b0, 1'b0, 32'h4000_0000, 4'd2, "R2 r5 never");
        probe(32'h9000_0000, 1'b0, 1'b0, 32'h9000_0000, 4'd0, "R2 r9 never");
        write_cfg(32'h0000_0002, 1'b1);
        probe(32'h1000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd0, "R2 r1 off");
        probe(32'h3000_0000, 1'b1, 1'b0, 32'h2000_0000, 4'd1, "R2 r3 on");
        write_cfg(32'h0000_0003, 1'b0);
        probe(32'h1000_0000, 1'b1, 1'b0, 32'h0000_0000, 4'd0, "R2 both r1");
        probe(32'h3000_0000, 1'b1, 1'b0, 32'h2000_0000, 4'd1, "R2 both r3");
        // R5: data moves without the strobe
        @(negedge clk);
        cfg_wr_data = 32'h0000_0000;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R5 no strobe", cfg_rd_data, 32'h0000_0003);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R4 re-reset rd", cfg_rd_data, 32'd0);
        probe(32'h3000_0000, 1'b0, 1'b0, 32'h2000_0000, 4'd1, "R4 nsc cleared");
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_plain_regions();
        t_sram();
        t_nonsec_periph();
        t_secure_window();
        t_exempt();
        t_nsc_config();
        t_reset_again();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule